// File: doc/BRIEF.md
# Disk Rotational Position Timer

This block tracks where a head-per-track disk is in its rotation. It keeps the angle as a word index that steps once per programmable interword period. The index wraps around a track of 2048 words. From the index the block derives three outputs:

- a photocell flag that marks the start of the track;
- a match flag that software-visible logic uses for an "address confirmed" skip test;
- a one-cycle start strobe that tells a separate transfer engine when the requested word passes under the heads.

A transfer request captures the target word. The block then counts the rotational wait in word slots. That wait is the target minus the current position, taken modulo the track length. When the count runs out, the block fires the strobe. A new request replaces one still pending, and reset drops it. `rst_n` is asserted asynchronously and is expected to be released in step with the clock by the surrounding reset tree.

Top module: `drum_pos_timer`

## Requirements
- R1: While `rst_n` is low and in the cycle after it is released, `pos_o` is 0 and `start_o` is 0.
- R2: With a constant period P ≥ 1, after the k-th rising edge following reset release, `pos_o` equals floor(k / P) mod 2048, so the position steps by exactly one every P clocks.
- R3: A period input of 0 behaves as a period of 1, so the position advances on every clock.
- R4: After position 2047 the next step returns the position to 0.
- R5: `pcell_o` is 1 exactly while `pos_o` is below 6 (words 0 to 5) and 0 for all other positions.
- R6: `match_o` is 1 exactly when `pos_o` equals `target_i`, whether or not a request is pending.
- R7: A request is sampled at a rising edge with `start_req_i` high, together with `target_i`. `start_o` then goes high in the first cycle, at or after that edge, in which `pos_o` equals the sampled target. The wait is therefore (target − position) mod 2048 word slots. A wait of zero gives the strobe in the cycle right after the sampling edge.
- R8: Each request gives exactly one single-cycle strobe, and no strobe appears without a request.
- R9: A request made while an earlier one is pending replaces it. Only the newer target produces a strobe.
- R10: Asserting reset cancels a pending request, and no strobe follows for it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| period_i | input | 24 | Clocks per word slot (0 treated as 1) |
| target_i | input | 11 | Word address within the track |
| start_req_i | input | 1 | Transfer request, sampled at the clock edge |
| pos_o | output | 11 | Current rotational word index |
| pcell_o | output | 1 | Photocell flag, high for the first six words |
| match_o | output | 1 | Current position equals `target_i` |
| start_o | output | 1 | One-cycle strobe when the requested word arrives |

## Verification
A wrong prescaler count shows up at `pos_o` within one period. It appears as a step taken early or late, and the step checks at chosen edges catch it. A corrupted slot countdown is invisible until the strobe. The strobe then fires at a position other than the target, up to a full rotation away. For that reason every request check compares both the strobe's cycle and `pos_o` in that cycle. A lost or stuck pending state shows as a missing strobe, a repeated strobe, or a strobe after reset. These are caught by counting strobes over windows that span the old target.

// File: rtl/drum_pos_pkg.sv
package drum_pos_pkg;
  localparam int unsigned DEF_WORD_W   = 11;
  localparam int unsigned DEF_PERIOD_W = 24;
  localparam int unsigned DEF_PCELL    = 6;

  typedef enum logic [0:0] {
    LNCH_IDLE = 1'b0,
    LNCH_WAIT = 1'b1
  } lnch_state_e;
endpackage

// File: rtl/drum_prescaler.sv
module drum_prescaler #(
  parameter int unsigned PERIOD_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                tick_o
);
  logic [PERIOD_W-1:0] cnt_q, cnt_d;
  logic [PERIOD_W-1:0] last_cnt;
  logic                tick;

  always_comb begin
    last_cnt = (period_i == '0) ? '0 : (period_i - PERIOD_W'(1));
    tick     = (cnt_q >= last_cnt);
    cnt_d    = tick ? '0 : (cnt_q + PERIOD_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = tick;
endmodule

// File: rtl/drum_position.sv
module drum_position #(
  parameter int unsigned WORD_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,
  output logic [WORD_W-1:0] pos_o,
  output logic [WORD_W-1:0] pos_next_o
);
  logic [WORD_W-1:0] pos_q, pos_d;

  always_comb begin
    pos_d = pos_q;
    if (adv_i) pos_d = pos_q + WORD_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  assign pos_o      = pos_q;
  assign pos_next_o = pos_d;
endmodule

// File: rtl/drum_launch.sv
module drum_launch
  import drum_pos_pkg::*;
#(
  parameter int unsigned WORD_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [WORD_W-1:0] target_i,
  input  logic [WORD_W-1:0] pos_next_i,
  input  logic              adv_i,
  output logic              start_o
);
  lnch_state_e       st_q, st_d;
  logic [WORD_W-1:0] slots_q, slots_d;
  logic              fire;

  always_comb begin
    fire    = (st_q == LNCH_WAIT) && (slots_q == '0);
    st_d    = st_q;
    slots_d = slots_q;
    if (fire) begin
      st_d = LNCH_IDLE;
    end else if ((st_q == LNCH_WAIT) && adv_i) begin
      slots_d = slots_q - WORD_W'(1);
    end
    if (req_i) begin
      st_d    = LNCH_WAIT;
      slots_d = target_i - pos_next_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= LNCH_IDLE;
      slots_q <= '0;
    end else begin
      st_q    <= st_d;
      slots_q <= slots_d;
    end
  end

  assign start_o = fire;
endmodule

// File: rtl/drum_pos_timer.sv
module drum_pos_timer
  import drum_pos_pkg::*;
#(
  parameter int unsigned WORD_W     = DEF_WORD_W,
  parameter int unsigned PERIOD_W   = DEF_PERIOD_W,
  parameter int unsigned PCELL_SPAN = DEF_PCELL
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic [WORD_W-1:0]   target_i,
  input  logic                start_req_i,
  output logic [WORD_W-1:0]   pos_o,
  output logic                pcell_o,
  output logic                match_o,
  output logic                start_o
);
  localparam logic [WORD_W-1:0] SPAN_V = WORD_W'(PCELL_SPAN);

  logic              tick;
  logic [WORD_W-1:0] pos;
  logic [WORD_W-1:0] pos_next;

  drum_prescaler #(.PERIOD_W(PERIOD_W)) u_presc (
    .clk      (clk),
    .rst_n    (rst_n),
    .period_i (period_i),
    .tick_o   (tick)
  );

  drum_position #(.WORD_W(WORD_W)) u_pos (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv_i      (tick),
    .pos_o      (pos),
    .pos_next_o (pos_next)
  );

  drum_launch #(.WORD_W(WORD_W)) u_lnch (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (start_req_i),
    .target_i   (target_i),
    .pos_next_i (pos_next),
    .adv_i      (tick),
    .start_o    (start_o)
  );

  generate
    if (PCELL_SPAN == 0) begin : g_no_pcell
      assign pcell_o = 1'b0;
    end else begin : g_pcell
      assign pcell_o = (pos < SPAN_V);
    end
  endgenerate

  assign match_o = (pos == target_i);
  assign pos_o   = pos;
endmodule

// File: rtl/drum_pos_timer_chk.sv
module drum_pos_timer_chk #(
  parameter int unsigned WORD_W     = 11,
  parameter int unsigned PCELL_SPAN = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_req_i,
  input logic [WORD_W-1:0] target_i,
  input logic [WORD_W-1:0] pos_o,
  input logic              pcell_o,
  input logic              start_o
);
  logic [WORD_W-1:0] tgt_q;
  logic              armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q   <= '0;
      armed_q <= 1'b0;
    end else if (start_req_i) begin
      tgt_q   <= target_i;
      armed_q <= 1'b1;
    end else if (start_o) begin
      armed_q <= 1'b0;
    end
  end

  assert_pos_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pos_o == $past(pos_o)) || (pos_o == ($past(pos_o) + WORD_W'(1))));

  assert_pcell_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pcell_o) |-> (pos_o == '0));

  assert_pcell_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pcell_o) |-> (pos_o == WORD_W'(PCELL_SPAN)));

  assert_strobe_at_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> (pos_o == tgt_q));

  assert_strobe_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> armed_q);

  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o && !start_req_i) |=> !start_o);
endmodule

bind drum_pos_timer drum_pos_timer_chk #(
  .WORD_W     (WORD_W),
  .PCELL_SPAN (PCELL_SPAN)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_req_i (start_req_i),
  .target_i    (target_i),
  .pos_o       (pos_o),
  .pcell_o     (pcell_o),
  .start_o     (start_o)
);

// File: tb/tb_drum_pos_timer.sv
`timescale 1ns/1ps
module tb_drum_pos_timer;
  localparam int TRACK = 2048;
  localparam int NVEC  = 8;
  // period, target, request edge
  localparam int VEC [NVEC][3] = '{
    '{10, 0,    1},
    '{10, 5,    3},
    '{4,  2,    9},
    '{3,  1,    4},
    '{3,  2,    3},
    '{1,  5,    100},
    '{2,  2047, 10},
    '{7,  0,    20}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [23:0] period_i;
  logic [10:0] target_i;
  logic        start_req_i;
  logic [10:0] pos_o;
  logic        pcell_o, match_o, start_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  drum_pos_timer dut (
    .clk(clk), .rst_n(rst_n), .period_i(period_i), .target_i(target_i),
    .start_req_i(start_req_i), .pos_o(pos_o), .pcell_o(pcell_o),
    .match_o(match_o), .start_o(start_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input int per);
    @(negedge clk);
    rst_n       = 1'b0;
    start_req_i = 1'b0;
    period_i    = 24'(per);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic int exp_latency(input int p, input int t, input int e);
    int s0, s, k;
    s0 = e / p;
    s  = s0 + ((((t - s0) % TRACK) + TRACK) % TRACK);
    k  = (s * p > e) ? s * p : e;
    return k - e;
  endfunction

  initial begin
    #950000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start_req_i = 1'b0; period_i = 24'd10; target_i = '0;

    // R1 reset state
    do_reset(10);
    chk("R1 pos after reset", int'(pos_o), 0);
    chk("R1 no strobe after reset", int'(start_o), 0);
    chk("R5 pcell at word 0", int'(pcell_o), 1);
    chk("R6 match at reset with target 0", int'(match_o), 1);

    // R2 step timing with period 10
    step(29);
    chk("R2 pos after edge 29", int'(pos_o), 2);
    step(1);
    chk("R2 pos after edge 30", int'(pos_o), 3);

    // R3 zero period acts as one
    do_reset(0);
    step(7);
    chk("R3 pos after 7 edges, period 0", int'(pos_o), 7);

    // R5 R6 R4 R8 sweep with period 1, no request
    target_i = 11'd6;
    do_reset(1);
    begin
      int strobes = 0;
      for (int e = 1; e <= 2048; e++) begin
        step(1);
        if (start_o) strobes++;
        if (e == 5) begin
          chk("R5 pcell at word 5", int'(pcell_o), 1);
          chk("R6 no match at word 5", int'(match_o), 0);
        end
        if (e == 6) begin
          chk("R5 pcell clear at word 6", int'(pcell_o), 0);
          chk("R6 match at word 6", int'(match_o), 1);
        end
        if (e == 2047) chk("R4 pos at 2047", int'(pos_o), 2047);
        if (e == 2048) begin
          chk("R4 pos wraps to 0", int'(pos_o), 0);
          chk("R5 pcell back after wrap", int'(pcell_o), 1);
        end
      end
      chk("R8 no strobe without request", strobes, 0);
    end

    // R7 R8 vector table
    for (int v = 0; v < NVEC; v++) begin
      int p, t, e, k, lat, exp;
      p = VEC[v][0]; t = VEC[v][1]; e = VEC[v][2];
      exp = exp_latency(p, t, e);
      do_reset(p);
      target_i = 11'(t);
      if (e > 1) step(e - 1);
      start_req_i = 1'b1;
      step(1);
      start_req_i = 1'b0;
      k = e;
      while (!start_o && (k < e + 30000)) begin
        step(1);
        k++;
      end
      lat = k - e;
      chk($sformatf("R7 latency vec %0d", v), lat, exp);
      chk($sformatf("R7 pos at strobe vec %0d", v), int'(pos_o), t);
      step(1);
      chk($sformatf("R8 strobe one cycle vec %0d", v), int'(start_o), 0);
    end

    // R9 replacement
    do_reset(1);
    target_i = 11'd50;
    start_req_i = 1'b1;
    step(1);
    start_req_i = 1'b0;
    step(8);
    target_i = 11'd20;
    start_req_i = 1'b1;
    step(1);
    start_req_i = 1'b0;
    begin
      int strobes = 0;
      int at = -1;
      for (int e = 10; e <= 60; e++) begin
        if (start_o) begin strobes++; at = int'(pos_o); end
        step(1);
      end
      chk("R9 single strobe after replace", strobes, 1);
      chk("R9 strobe at newer target", at, 20);
    end

    // R10 reset cancels pending
    do_reset(1);
    target_i = 11'd30;
    start_req_i = 1'b1;
    step(1);
    start_req_i = 1'b0;
    step(4);
    do_reset(1);
    chk("R1 pos after mid-run reset", int'(pos_o), 0);
    begin
      int strobes = 0;
      for (int e = 1; e <= 100; e++) begin
        step(1);
        if (start_o) strobes++;
      end
      chk("R10 no strobe after reset", strobes, 0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule